// File: doc/BRIEF.md
# Store Write Buffer with Byte-Merging Load Forwarding

This block sits in front of a single-ported data cache and decides, every cycle, whether a store leaving the writeback stage may use the cache port or must wait. A load issued by the address generator competes for the same port. A store that cannot go to the cache at once is parked in a one-entry holding slot. The slot drains on a later cycle in which the cache is idle. The writeback stage is stalled only when the slot is occupied, a new store is waiting and the cache is busy.

The same block also completes loads in the operand-fetch stage. It compares the load's word address against three pending stores: the store in execute, the store in writeback and the store in the holding slot. It then builds the load word byte by byte. Each byte comes from the youngest pending store that writes that byte, and from the cache's read data when no pending store writes it. The merged word is shifted by the load's byte offset and zero-extended to the load size, so that no overlap or alignment case ever needs a stall.

Top module: `stbuf_fwd`

## Requirements
- R1: After reset the slot is empty: `dc_wr_valid`, `wb_stall` and `ag_ld_hold` are all 0 while the inputs are idle.
- R2: With the slot empty, a writeback store (`wb_st_valid`=1) goes straight to the cache in the same cycle when `dc_busy`=0 and `ag_ld_req`=0. In that case `dc_wr_addr`, `dc_wr_data` and `dc_wr_be` equal the writeback store and the slot stays empty.
- R3: With the slot empty, a load request takes the cache port over a writeback store, and `dc_wr_valid` is 0 that cycle. The same holds when `dc_busy`=1. In both cases the store is captured into the slot at the clock edge, and `wb_stall` stays 0.
- R4: While the slot is occupied, it issues its store to the cache in any cycle with `dc_busy`=0, ahead of both writeback and loads. `ag_ld_hold` is 1 whenever `ag_ld_req`=1 and the slot is occupied.
- R5: When the occupied slot drains and a writeback store is present, that store moves into the slot at the same edge. `wb_stall` stays 0, and the store is written to the cache on the next idle cycle.
- R6: When the slot is occupied, a writeback store is present and `dc_busy`=1, `wb_stall` is 1, no cache write is requested, and the slot keeps its store.
- R7: Store addresses and the load address are compared on bits [AW-1:2], so a store in another word never affects the load. Among matching stores, each byte is taken from execute first, then writeback, then the slot, and otherwise from `dc_rd_data`.
- R8: Only bytes whose enable bit is set take part in forwarding. Enable bit b covers data bits [8b+7:8b], and a disabled byte falls through to the next older source or to the cache.
- R9: `of_ld_size` selects the load size: 0 means byte, 1 means halfword, and 2 or 3 mean word. The merged word is shifted right by 8·`of_ld_addr[1:0]` and zero-extended to 32 bits. Loads are naturally aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wb_st_valid | input | 1 | Store present in the writeback stage |
| wb_st_addr | input | AW | Byte address of the writeback store |
| wb_st_data | input | 32 | Writeback store data, placed in its byte lanes |
| wb_st_be | input | 4 | Byte enables of the writeback store |
| wb_stall | output | 1 | Writeback must hold its store this cycle |
| ag_ld_req | input | 1 | Load from the address generator requests the cache port |
| ag_ld_hold | output | 1 | Load request must wait because the slot owns the port |
| dc_busy | input | 1 | Cache cannot accept a request this cycle |
| dc_wr_valid | output | 1 | Cache write request |
| dc_wr_addr | output | AW | Cache write address |
| dc_wr_data | output | 32 | Cache write data |
| dc_wr_be | output | 4 | Cache write byte enables |
| ex_st_valid | input | 1 | Store present in the execute stage |
| ex_st_addr | input | AW | Execute store byte address |
| ex_st_data | input | 32 | Execute store data in byte lanes |
| ex_st_be | input | 4 | Execute store byte enables |
| of_ld_addr | input | AW | Byte address of the operand-fetch load |
| of_ld_size | input | 2 | Load size code (0 byte, 1 half, 2/3 word) |
| dc_rd_data | input | 32 | Cache read word for the operand-fetch load |
| of_ld_data | output | 32 | Merged, aligned, zero-extended load result |

## Verification
The assertions assume that writeback holds its store steady while `wb_stall` is high. They also assume that the execute and writeback stores describe in-flight stores younger than the slot's store. The stimulus keeps to this by having every scenario hold its writeback inputs unchanged across stalled cycles. Each scenario starts from reset, so the slot's contents are always known. Loads are always issued naturally aligned to their size, which the alignment checks rely on.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
  localparam int DW = 32;
  localparam int NB = DW / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD3 = 2'd3
  } ld_size_e;

  typedef struct packed {
    logic          valid;
    logic [DW-1:0] data;
    logic [NB-1:0] be;
  } st_lane_t;

  // shift a merged word down to its byte offset and zero-extend by size
  function automatic logic [DW-1:0] align_load(input logic [DW-1:0] word,
                                               input logic [1:0]    off,
                                               input logic [1:0]    size);
    logic [DW-1:0] sh;
    sh = word >> {off, 3'b000};
    case (size)
      SZ_BYTE: align_load = {{(DW-8){1'b0}},  sh[7:0]};
      SZ_HALF: align_load = {{(DW-16){1'b0}}, sh[15:0]};
      default: align_load = sh;
    endcase
  endfunction

  function automatic logic same_word(input logic [31:0] a, input logic [31:0] b);
    same_word = (a == b);
  endfunction
endpackage

// File: rtl/stbuf_arb.sv
module stbuf_arb (
  input  logic slot_full,
  input  logic wb_valid,
  input  logic ld_req,
  input  logic dc_busy,
  output logic issue_slot,
  output logic issue_wb,
  output logic capture_wb,
  output logic stall_wb,
  output logic hold_ld
);
  logic port_free_for_store;

  always_comb begin
    // loads win the port unless the slot is occupied
    port_free_for_store = !dc_busy && (slot_full || !ld_req);
    issue_slot = slot_full && port_free_for_store;
    issue_wb   = !slot_full && wb_valid && port_free_for_store;
    capture_wb = wb_valid && ((!slot_full && !port_free_for_store) || issue_slot);
    stall_wb   = wb_valid && slot_full && !issue_slot;
    hold_ld    = ld_req && slot_full;
  end
endmodule

// File: rtl/stbuf_slot.sv
module stbuf_slot #(
  parameter int AW = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_en,
  input  logic                      drain,
  input  logic [AW-1:0]             in_addr,
  input  stbuf_pkg::st_lane_t       in_lane,
  output logic                      full,
  output logic [AW-1:0]             addr,
  output stbuf_pkg::st_lane_t       lane
);
  import stbuf_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      addr <= '0;
      lane <= '0;
    end else begin
      if (load_en) begin
        full <= 1'b1;
        addr <= in_addr;
        lane <= in_lane;
      end else if (drain) begin
        full <= 1'b0;
        lane.valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stbuf_merge.sv
module stbuf_merge #(
  parameter int WW = 14
) (
  input  logic [WW-1:0]             ld_word,
  input  logic [WW-1:0]             ex_word,
  input  logic [WW-1:0]             wb_word,
  input  logic [WW-1:0]             sl_word,
  input  stbuf_pkg::st_lane_t       ex_lane,
  input  stbuf_pkg::st_lane_t       wb_lane,
  input  stbuf_pkg::st_lane_t       sl_lane,
  input  logic [stbuf_pkg::DW-1:0]  cache_word,
  output logic [stbuf_pkg::DW-1:0]  merged
);
  import stbuf_pkg::*;

  logic ex_hit, wb_hit, sl_hit;
  assign ex_hit = ex_lane.valid && (ex_word == ld_word);
  assign wb_hit = wb_lane.valid && (wb_word == ld_word);
  assign sl_hit = sl_lane.valid && (sl_word == ld_word);

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_comb begin
      if (ex_hit && ex_lane.be[b])
        merged[b*8 +: 8] = ex_lane.data[b*8 +: 8];
      else if (wb_hit && wb_lane.be[b])
        merged[b*8 +: 8] = wb_lane.data[b*8 +: 8];
      else if (sl_hit && sl_lane.be[b])
        merged[b*8 +: 8] = sl_lane.data[b*8 +: 8];
      else
        merged[b*8 +: 8] = cache_word[b*8 +: 8];
    end
  end
endmodule

// File: rtl/stbuf_fwd.sv
module stbuf_fwd #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wb_st_valid,
  input  logic [AW-1:0] wb_st_addr,
  input  logic [31:0]   wb_st_data,
  input  logic [3:0]    wb_st_be,
  output logic          wb_stall,
  input  logic          ag_ld_req,
  output logic          ag_ld_hold,
  input  logic          dc_busy,
  output logic          dc_wr_valid,
  output logic [AW-1:0] dc_wr_addr,
  output logic [31:0]   dc_wr_data,
  output logic [3:0]    dc_wr_be,
  input  logic          ex_st_valid,
  input  logic [AW-1:0] ex_st_addr,
  input  logic [31:0]   ex_st_data,
  input  logic [3:0]    ex_st_be,
  input  logic [AW-1:0] of_ld_addr,
  input  logic [1:0]    of_ld_size,
  input  logic [31:0]   dc_rd_data,
  output logic [31:0]   of_ld_data
);
  import stbuf_pkg::*;

  localparam int WW = AW - 2;

  st_lane_t      wb_lane, ex_lane, slot_lane;
  logic [AW-1:0] slot_addr;
  logic          slot_full;
  logic          issue_slot, issue_wb, capture_wb;
  logic [DW-1:0] merged_word;

  assign wb_lane = '{valid: wb_st_valid, data: wb_st_data, be: wb_st_be};
  assign ex_lane = '{valid: ex_st_valid, data: ex_st_data, be: ex_st_be};

  stbuf_arb u_arb (
    .slot_full  (slot_full),
    .wb_valid   (wb_st_valid),
    .ld_req     (ag_ld_req),
    .dc_busy    (dc_busy),
    .issue_slot (issue_slot),
    .issue_wb   (issue_wb),
    .capture_wb (capture_wb),
    .stall_wb   (wb_stall),
    .hold_ld    (ag_ld_hold)
  );

  stbuf_slot #(.AW(AW)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (capture_wb),
    .drain   (issue_slot),
    .in_addr (wb_st_addr),
    .in_lane (wb_lane),
    .full    (slot_full),
    .addr    (slot_addr),
    .lane    (slot_lane)
  );

  always_comb begin
    dc_wr_valid = issue_slot || issue_wb;
    if (slot_full) begin
      dc_wr_addr = slot_addr;
      dc_wr_data = slot_lane.data;
      dc_wr_be   = slot_lane.be;
    end else begin
      dc_wr_addr = wb_st_addr;
      dc_wr_data = wb_st_data;
      dc_wr_be   = wb_st_be;
    end
  end

  stbuf_merge #(.WW(WW)) u_merge (
    .ld_word    (of_ld_addr[AW-1:2]),
    .ex_word    (ex_st_addr[AW-1:2]),
    .wb_word    (wb_st_addr[AW-1:2]),
    .sl_word    (slot_addr[AW-1:2]),
    .ex_lane    (ex_lane),
    .wb_lane    (wb_lane),
    .sl_lane    (slot_lane),
    .cache_word (dc_rd_data),
    .merged     (merged_word)
  );

  assign of_ld_data = align_load(merged_word, of_ld_addr[1:0], of_ld_size);
endmodule

// File: rtl/stbuf_fwd_chk.sv
module stbuf_fwd_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wb_st_valid,
  input logic [AW-1:0] wb_st_addr,
  input logic          wb_stall,
  input logic          ag_ld_req,
  input logic          ag_ld_hold,
  input logic          dc_busy,
  input logic          dc_wr_valid,
  input logic [AW-1:0] dc_wr_addr,
  input logic          slot_full,
  input logic [AW-1:0] slot_addr,
  input logic          ex_st_valid,
  input logic [AW-1:0] ex_st_addr,
  input logic [31:0]   ex_st_data,
  input logic [3:0]    ex_st_be,
  input logic [AW-1:0] of_ld_addr,
  input logic [1:0]    of_ld_size,
  input logic [31:0]   of_ld_data
);
  AST_NO_WRITE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dc_busy |-> !dc_wr_valid); // R6

  AST_LOAD_WINS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_full && ag_ld_req) |-> !dc_wr_valid); // R3

  AST_BLOCKED_STORE_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_full && wb_st_valid && (dc_busy || ag_ld_req)) |=>
      (slot_full && slot_addr == $past(wb_st_addr))); // R3

  AST_SLOT_DRAINS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_full && !dc_busy) |-> (dc_wr_valid && dc_wr_addr == slot_addr)); // R4

  AST_HOLD_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ag_ld_hold |-> (slot_full && ag_ld_req)); // R4

  AST_STALL_KEEPS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stall |=> (slot_full && $stable(slot_addr))); // R6

  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stall |-> (wb_st_valid && dc_busy && slot_full)); // R6

  AST_EX_WORD_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_st_valid && ex_st_be == 4'hF && of_ld_size == 2'd2 && of_ld_addr[1:0] == 2'b00 &&
     ex_st_addr[AW-1:2] == of_ld_addr[AW-1:2]) |-> (of_ld_data == ex_st_data)); // R7
endmodule

bind stbuf_fwd stbuf_fwd_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wb_st_valid (wb_st_valid),
  .wb_st_addr  (wb_st_addr),
  .wb_stall    (wb_stall),
  .ag_ld_req   (ag_ld_req),
  .ag_ld_hold  (ag_ld_hold),
  .dc_busy     (dc_busy),
  .dc_wr_valid (dc_wr_valid),
  .dc_wr_addr  (dc_wr_addr),
  .slot_full   (slot_full),
  .slot_addr   (slot_addr),
  .ex_st_valid (ex_st_valid),
  .ex_st_addr  (ex_st_addr),
  .ex_st_data  (ex_st_data),
  .ex_st_be    (ex_st_be),
  .of_ld_addr  (of_ld_addr),
  .of_ld_size  (of_ld_size),
  .of_ld_data  (of_ld_data)
);

// File: tb/stbuf_fwd_bench.sv
module stbuf_fwd_bench;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wb_st_valid;
  logic [AW-1:0] wb_st_addr;
  logic [31:0]   wb_st_data;
  logic [3:0]    wb_st_be;
  logic          wb_stall;
  logic          ag_ld_req;
  logic          ag_ld_hold;
  logic          dc_busy;
  logic          dc_wr_valid;
  logic [AW-1:0] dc_wr_addr;
  logic [31:0]   dc_wr_data;
  logic [3:0]    dc_wr_be;
  logic          ex_st_valid;
  logic [AW-1:0] ex_st_addr;
  logic [31:0]   ex_st_data;
  logic [3:0]    ex_st_be;
  logic [AW-1:0] of_ld_addr;
  logic [1:0]    of_ld_size;
  logic [31:0]   dc_rd_data;
  logic [31:0]   of_ld_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stbuf_fwd #(.AW(AW)) u_stbuf_fwd (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic idle_inputs();
    wb_st_valid = 0; wb_st_addr = '0; wb_st_data = '0; wb_st_be = '0;
    ag_ld_req = 0; dc_busy = 0;
    ex_st_valid = 0; ex_st_addr = '0; ex_st_data = '0; ex_st_be = '0;
    of_ld_addr = '0; of_ld_size = 2'd2; dc_rd_data = 32'hC3C2C1C0;
  endtask

  // next cycle: step to the following falling edge, then let logic settle
  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    step(); step();
    rst_n = 1;
    step();
  endtask

  task automatic set_wb(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
    wb_st_valid = 1; wb_st_addr = a; wb_st_data = d; wb_st_be = be;
  endtask

  task automatic t_reset();
    do_reset();
    settle();
    chk_eq("R1 wr_valid", {31'b0, dc_wr_valid}, 32'd0);
    chk_eq("R1 stall", {31'b0, wb_stall}, 32'd0);
    chk_eq("R1 hold", {31'b0, ag_ld_hold}, 32'd0);
  endtask

  task automatic t_direct();
    do_reset();
    set_wb(16'h0040, 32'hDEADBEEF, 4'h5);
    settle();
    chk_eq("R2 wr_valid", {31'b0, dc_wr_valid}, 32'd1);
    chk_eq("R2 wr_addr", {16'b0, dc_wr_addr}, 32'h0040);
    chk_eq("R2 wr_data", dc_wr_data, 32'hDEADBEEF);
    chk_eq("R2 wr_be", {28'b0, dc_wr_be}, 32'h5);
    step();
    wb_st_valid = 0;
    settle();
    chk_eq("R2 slot stays empty", {31'b0, dc_wr_valid}, 32'd0);
  endtask

  task automatic t_load_priority();
    do_reset();
    set_wb(16'h0010, 32'h11111111, 4'hF);
    ag_ld_req = 1;
    settle();
    chk_eq("R3 load wins port", {31'b0, dc_wr_valid}, 32'd0);
    chk_eq("R3 no stall", {31'b0, wb_stall}, 32'd0);
    chk_eq("R3 no hold", {31'b0, ag_ld_hold}, 32'd0);
    step();
    wb_st_valid = 0;
    settle();
    chk_eq("R4 hold while slot full", {31'b0, ag_ld_hold}, 32'd1);
    chk_eq("R4 slot drains over load", {31'b0, dc_wr_valid}, 32'd1);
    chk_eq("R4 drained addr", {16'b0, dc_wr_addr}, 32'h0010);
    chk_eq("R4 drained data", dc_wr_data, 32'h11111111);
    step();
    settle();
    chk_eq("R4 slot empty after drain", {31'b0, ag_ld_hold}, 32'd0);
  endtask

  task automatic t_stall_and_refill();
    do_reset();
    set_wb(16'h0100, 32'hAAAA0001, 4'hF);
    dc_busy = 1;
    settle();
    chk_eq("R3 busy blocks store", {31'b0, dc_wr_valid}, 32'd0);
    chk_eq("R3 busy no stall", {31'b0, wb_stall}, 32'd0);
    step();
    set_wb(16'h0200, 32'hBBBB0002, 4'h3);
    settle();
    chk_eq("R6 stall asserted", {31'b0, wb_stall}, 32'd1);
    chk_eq("R6 no write", {31'b0, dc_wr_valid}, 32'd0);
    step();
    settle();
    chk_eq("R6 still stalled", {31'b0, wb_stall}, 32'd1);
    dc_busy = 0;
    settle();
    chk_eq("R5 no stall on drain", {31'b0, wb_stall}, 32'd0);
    chk_eq("R5 slot kept first store", {16'b0, dc_wr_addr}, 32'h0100);
    chk_eq("R5 slot data", dc_wr_data, 32'hAAAA0001);
    step();
    wb_st_valid = 0;
    settle();
    chk_eq("R5 refilled write", {31'b0, dc_wr_valid}, 32'd1);
    chk_eq("R5 refilled addr", {16'b0, dc_wr_addr}, 32'h0200);
    chk_eq("R5 refilled be", {28'b0, dc_wr_be}, 32'h3);
    step();
    settle();
    chk_eq("R5 empty afterwards", {31'b0, dc_wr_valid}, 32'd0);
  endtask

  task automatic t_forward_priority();
    do_reset();
    // slot: full word; held in place by busy cache
    set_wb(16'h0300, 32'hB0B1B2B3, 4'hF);
    dc_busy = 1;
    step();
    set_wb(16'h0302, 32'hAAAAA1A0, 4'h3);
    ex_st_valid = 1; ex_st_addr = 16'h0301; ex_st_data = 32'h0000E100; ex_st_be = 4'h2;
    of_ld_addr = 16'h0300; of_ld_size = 2'd2;
    settle();
    chk_eq("R7 three-source merge", of_ld_data, 32'hB0B1E1A0);
    of_ld_addr = 16'h0304;
    settle();
    chk_eq("R7 other word uses cache", of_ld_data, 32'hC3C2C1C0);
    of_ld_addr = 16'h0300;
    ex_st_addr = 16'h0304;
    settle();
    chk_eq("R7 ex other word skipped", of_ld_data, 32'hB0B1A1A0);
    ex_st_addr = 16'h0300; ex_st_be = 4'hF; ex_st_data = 32'h12345678;
    settle();
    chk_eq("R7 ex full word wins", of_ld_data, 32'h12345678);
  endtask

  task automatic t_forward_partial();
    do_reset();
    dc_busy = 1;
    set_wb(16'h0400, 32'h00550000, 4'h4);
    of_ld_addr = 16'h0400; of_ld_size = 2'd2;
    settle();
    chk_eq("R8 one enabled byte", of_ld_data, 32'hC355C1C0);
    wb_st_be = 4'h0;
    settle();
    chk_eq("R8 no enabled byte", of_ld_data, 32'hC3C2C1C0);
  endtask

  task automatic t_align();
    do_reset();
    dc_busy = 1;
    of_ld_addr = 16'h0502; of_ld_size = 2'd0;
    settle();
    chk_eq("R9 byte off2", of_ld_data, 32'h000000C2);
    of_ld_size = 2'd1;
    settle();
    chk_eq("R9 half off2", of_ld_data, 32'h0000C3C2);
    of_ld_addr = 16'h0501; of_ld_size = 2'd0;
    settle();
    chk_eq("R9 byte off1", of_ld_data, 32'h000000C1);
    of_ld_addr = 16'h0500; of_ld_size = 2'd3;
    settle();
    chk_eq("R9 size3 word", of_ld_data, 32'hC3C2C1C0);
    set_wb(16'h0500, 32'h77000000, 4'h8);
    of_ld_addr = 16'h0503; of_ld_size = 2'd0;
    settle();
    chk_eq("R9 forwarded byte off3", of_ld_data, 32'h00000077);
  endtask

  initial begin
    rst_n = 0;
    idle_inputs();
    t_reset();
    t_direct();
    t_load_priority();
    t_stall_and_refill();
    t_forward_priority();
    t_forward_partial();
    t_align();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule